// File: doc/BRIEF.md
# Interrupt-Driven Data Transfer Channels

This block is a set of transfer channels that service interrupt requests without running a CPU service routine. Each channel holds a source pointer, a destination pointer and a control word. The control word selects the transfer size (byte or word), which pointer advances, and how many transfers remain. When an interrupt request reaches a channel that still has transfers left, the block copies one item from the source address to the destination address in a single cycle. During that cycle it holds the CPU stalled, and it raises no interrupt.

The memory port uses a combinational read address and read data path, followed by a write strobe in the same cycle. The data move therefore costs exactly one stolen cycle. A channel whose count has run out passes its request on to the CPU as a normal interrupt. When several channels are pending together, they are served one per cycle, highest channel number first. A simple write port loads the per-channel registers.

Top module: `xfer_chan_set`

## Requirements
- R1: A configuration write with `cfg_we` high updates channel `cfg_ch` at the next clock edge. `cfg_sel` selects the target: 0 is the control word, 1 is the source pointer and 2 is the destination pointer. In the control word, bits 7:0 hold the transfer count, bits 9:8 hold the increment mode and bit 10 set selects word size.
- R2: During a transfer, `rd_addr` carries the source pointer and `wr_addr` carries the destination pointer, with `wr_en` and `wr_word` valid. A word transfer forces bit 0 of both addresses to zero and copies `rd_data` whole. A byte transfer uses the pointers unchanged and writes the low byte of `rd_data` zero-extended.
- R3: After each transfer, the increment mode decides which pointer advances: 00 neither, 01 the destination only, 10 the source only, 11 neither. The step is 1 for byte transfers and 2 for word transfers. Both pointers never advance together.
- R4: Each transfer lowers a count below 0xFF by one. A request that arrives when the count is zero, or when the channel's final transfer is taking place in that same cycle, appears on `cpu_irq` for that channel in the same cycle and causes no transfer.
- R5: A count of 0xFF is never decremented, so the channel keeps transferring on every request.
- R6: A request sampled at a clock edge produces its transfer in the next cycle. `cpu_stall` and `wr_en` are high only in cycles that carry a transfer, with one transfer per stalled cycle.
- R7: Among pending channels, the highest-numbered one is served first. Each remaining channel follows in a later cycle, one per cycle, in descending order.
- R8: After reset, no request is pending, every count is zero and `cpu_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CW | Channel addressed by the write |
| cfg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination |
| cfg_wdata | input | AW | Write data |
| irq_req | input | NCH | Interrupt request per channel |
| cpu_irq | output | NCH | Requests passed on to the CPU |
| cpu_stall | output | 1 | CPU held for the current cycle |
| rd_addr | output | AW | Memory read address |
| rd_data | input | DW | Memory read data |
| wr_en | output | 1 | Memory write strobe |
| wr_word | output | 1 | Write is a full word (else low byte) |
| wr_addr | output | AW | Memory write address |
| wr_data | output | DW | Memory write data |

## Verification
The assertions check the following on every cycle:
- at most one channel is granted;
- a granted channel has a non-zero count;
- a 0xFF count stays put across a transfer;
- a transfer never moves both pointers;
- word addresses are even.

Only the bench scenarios can show the rest: the exact addresses and data of successive transfers, the order in which simultaneous requests are served, and the hand-off to the CPU once the count runs out, including a request that arrives while the last transfer is under way.

// File: rtl/xfer_chan_set.sv
module xfer_chan_set #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CW-1:0]  cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic [NCH-1:0] irq_req,
  output logic [NCH-1:0] cpu_irq,
  output logic           cpu_stall,
  output logic [AW-1:0]  rd_addr,
  input  logic [DW-1:0]  rd_data,
  output logic           wr_en,
  output logic           wr_word,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data
);
  localparam logic [1:0] INC_DST = 2'b01;
  localparam logic [1:0] INC_SRC = 2'b10;

  logic [7:0]    cnt  [NCH];
  logic [1:0]    mode [NCH];
  logic          word [NCH];
  logic [AW-1:0] src  [NCH];
  logic [AW-1:0] dst  [NCH];
  logic [NCH-1:0] pend, grant, elig;
  logic [CW-1:0]  sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NCH; i++)
      if (pend[i]) sel = CW'(i);
  end

  assign grant     = (|pend) ? (NCH'(1) << sel) : '0;
  assign cpu_stall = |pend;
  assign wr_en     = cpu_stall;
  assign wr_word   = word[sel];
  assign rd_addr   = word[sel] ? {src[sel][AW-1:1], 1'b0} : src[sel];
  assign wr_addr   = word[sel] ? {dst[sel][AW-1:1], 1'b0} : dst[sel];
  assign wr_data   = word[sel] ? rd_data : {{(DW-8){1'b0}}, rd_data[7:0]};

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = (cnt[g] != 8'd0) && !(grant[g] && cnt[g] == 8'd1);
  end
  assign cpu_irq = irq_req & ~elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      for (int i = 0; i < NCH; i++) begin
        cnt[i]  <= '0;
        mode[i] <= '0;
        word[i] <= 1'b0;
        src[i]  <= '0;
        dst[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        pend[i] <= (pend[i] & ~grant[i]) | (irq_req[i] & elig[i]);
        if (grant[i]) begin
          if (cnt[i] != 8'hFF) cnt[i] <= cnt[i] - 8'd1;
          if (mode[i] == INC_DST) dst[i] <= dst[i] + (word[i] ? AW'(2) : AW'(1));
          if (mode[i] == INC_SRC) src[i] <= src[i] + (word[i] ? AW'(2) : AW'(1));
        end
        if (cfg_we && cfg_ch == CW'(i)) begin
          case (cfg_sel)
            2'd0: begin
              cnt[i]  <= cfg_wdata[7:0];
              mode[i] <= cfg_wdata[9:8];
              word[i] <= cfg_wdata[10];
            end
            2'd1: src[i] <= cfg_wdata;
            2'd2: dst[i] <= cfg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_stall_is_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> wr_en && $countones(grant) == 1);

  assert_word_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word) |-> !rd_addr[0] && !wr_addr[0]);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_count_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |-> cnt[g] != 8'd0);

    assert_endless_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[g] && cnt[g] == 8'hFF && !cfg_we) |=> cnt[g] == 8'hFF);

    assert_one_pointer_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[g] && !cfg_we) |=> !(src[g] != $past(src[g]) && dst[g] != $past(dst[g])));
  end
endmodule

// File: tb/xfer_chan_set_tb.sv
`timescale 1ns/1ps
module xfer_chan_set_tb;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [NCH-1:0] irq_req = '0;
  logic [NCH-1:0] cpu_irq;
  logic cpu_stall, wr_en, wr_word;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic [NCH-1:0] irq_seen;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign rd_data = rd_addr ^ 16'h5A3C;

  xfer_chan_set #(.NCH(NCH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .irq_req(irq_req),
    .cpu_irq(cpu_irq), .cpu_stall(cpu_stall), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_word(wr_word),
    .wr_addr(wr_addr), .wr_data(wr_data));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int s, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(s); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic trig(input logic [NCH-1:0] m);
    @(negedge clk);
    irq_req = m;
    #1 irq_seen = cpu_irq;
    @(negedge clk);
    irq_req = '0;
    #1;
  endtask

  function automatic logic [AW-1:0] al(input logic [AW-1:0] p, input bit w);
    return w ? {p[AW-1:1], 1'b0} : p;
  endfunction

  task automatic xfer_check(input logic [AW-1:0] es, input logic [AW-1:0] ed, input bit w, input string tag);
    logic [DW-1:0] ev;
    ev = al(es, w) ^ 16'h5A3C;
    if (!w) ev = {8'h00, ev[7:0]};
    check(cpu_stall === 1'b1 && wr_en === 1'b1, {tag, " R6 stall"}, {cpu_stall, wr_en}, 2'b11);
    check(rd_addr === al(es, w), {tag, " R2 rd_addr"}, rd_addr, al(es, w));
    check(wr_addr === al(ed, w), {tag, " R2 wr_addr"}, wr_addr, al(ed, w));
    check(wr_data === ev, {tag, " R2 wr_data"}, wr_data, ev);
    check(wr_word === w, {tag, " R2 wr_word"}, wr_word, w);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    check(cpu_stall === 1'b0, "R8 stall in reset", cpu_stall, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check(cpu_stall === 1'b0 && wr_en === 1'b0, "R8 idle after reset", {cpu_stall, wr_en}, 0);
    trig(4'b0100);
    check(irq_seen === 4'b0100, "R8 R4 zero count after reset passes request", irq_seen, 4'b0100);
    check(cpu_stall === 1'b0, "R8 no transfer after reset", cpu_stall, 0);

    for (int ch = 0; ch < NCH; ch++)
      for (int md = 0; md < 4; md++)
        for (int w = 0; w < 2; w++) begin
          logic [AW-1:0] es, ed, step;
          es = 16'h1001 + 16'(ch * 16'h100);
          ed = 16'h8003 + 16'(md * 16'h40);
          step = w ? 16'd2 : 16'd1;
          cfg(ch, 0, {5'b0, 1'(w), 2'(md), 8'd3});
          cfg(ch, 1, es);
          cfg(ch, 2, ed);
          for (int k = 0; k < 3; k++) begin
            trig(4'(1 << ch));
            check(irq_seen === 4'b0, "R4 live count keeps request", irq_seen, 0);
            xfer_check(es, ed, 1'(w), "R1 R3 sweep");
            if (md == 1) ed = ed + step;
            if (md == 2) es = es + step;
            @(negedge clk); #1;
            check(cpu_stall === 1'b0, "R6 single stall cycle", cpu_stall, 0);
          end
          trig(4'(1 << ch));
          check(irq_seen === 4'(1 << ch), "R4 exhausted count passes request", irq_seen, 4'(1 << ch));
          check(cpu_stall === 1'b0, "R4 no transfer when exhausted", cpu_stall, 0);
        end

    for (int i = 0; i < NCH; i++) begin
      cfg(i, 0, {5'b0, 1'b0, 2'b00, 8'hFF});
      cfg(i, 1, 16'h4000 + 16'(i));
      cfg(i, 2, 16'h6000 + 16'(i));
    end
    trig(4'b1011);
    xfer_check(16'h4003, 16'h6003, 1'b0, "R7 first ch3");
    @(negedge clk); #1;
    xfer_check(16'h4001, 16'h6001, 1'b0, "R7 second ch1");
    @(negedge clk); #1;
    xfer_check(16'h4000, 16'h6000, 1'b0, "R7 third ch0");
    @(negedge clk); #1;
    check(cpu_stall === 1'b0, "R7 queue drained", cpu_stall, 0);

    for (int k = 0; k < 6; k++) begin
      trig(4'b0001);
      check(irq_seen === 4'b0, "R5 endless count never passes request", irq_seen, 0);
      xfer_check(16'h4000, 16'h6000, 1'b0, "R5 endless transfers");
    end

    cfg(2, 0, {5'b0, 1'b1, 2'b10, 8'd1});
    cfg(2, 1, 16'h2000);
    @(negedge clk);
    irq_req = 4'b0100;
    @(negedge clk);
    #1;
    check(cpu_stall === 1'b1, "R4 last transfer running", cpu_stall, 1);
    check(cpu_irq === 4'b0100, "R4 request during last transfer goes to CPU", cpu_irq, 4'b0100);
    @(negedge clk);
    irq_req = '0;
    #1 check(cpu_stall === 1'b0, "R4 no transfer after last", cpu_stall, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule